// File: doc/BRIEF.md
# Free-Running Cycle Counter with Tear-Checked Two-Half Readout

This block keeps a wide cycle counter that advances by one on every clock once software has switched it on. The counter is twice the width of the register bus. Software therefore reads it in two pieces through three auxiliary register addresses: a control/status word, the lower half and the upper half. No shadow copy of the upper half is kept. Instead, a small tracker watches the read accesses and reports whether the most recent lower-then-upper pair could have been torn.

Two events can tear a pair. The first is a carry from the lower half into the upper half between the two reads. The second is the core taking an exception or interrupt in that window, which it signals with a one-cycle strobe. Software reads the lower half, then the upper half, then the control word. It repeats the three reads until the status bit reports a clean pair.

Read data is combinational and valid in the same cycle as the read strobe. Reads update the tracker at the clock edge that ends the read cycle.

Top module: `snap_cycle_ctr`

## Requirements
- R1: Reset (asynchronous, active low) clears the counter, the enable and the tracker, so that the control, lower and upper addresses all read 0.
- R2: Writing the control address (default 0x103) loads bit 0 of the write data into the enable. Bit 0 of the control word reads the enable back. All control bits other than bit 0 and the status bit read 0.
- R3: While enabled, the counter rises by exactly 1 per clock. While disabled, it holds its value. A read of the lower address (default 0x104) returns counter bits [DATA_W-1:0], and a read of the upper address (default 0x105) returns the bits above them, both as sampled in the read cycle.
- R4: A lower read followed later by an upper read, with no tearing event in between, sets the status bit (bit DATA_W-1 of the control word) to 1 from the cycle after the upper read.
- R5: A carry out of the lower half makes the pair report status 0 if it lands at any clock edge from the edge ending the lower read through the edge just before the upper read. A carry at the edge that ends the upper read does not tear the pair.
- R6: An exception strobe makes the pair report status 0 if it is raised in any cycle from the lower read through the cycle before the upper read. A strobe in the upper-read cycle, or outside the window, has no effect on the status.
- R7: An upper read that is not preceded by a lower read since the last completed pair sets the status to 0.
- R8: Between a lower read and its upper read the status reads 0. A further lower read in that window restarts the window and discards any tearing seen so far.
- R9: Reading the control word does not change the tracker, so repeated control reads return the same status.
- R10: Reads of any address other than the three mapped ones return 0. Writes to any address other than the control address change neither the counter nor the enable.
- R11: The bus width DATA_W is a parameter (default 32, at least 2). The counter is 2*DATA_W bits wide and the status bit sits at bit DATA_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aux_addr | input | ADDR_W | Register address for a read or write |
| aux_rd_en | input | 1 | Read strobe, one per access cycle |
| aux_wr_en | input | 1 | Write strobe |
| aux_wdata | input | DATA_W | Write data |
| exc_taken | input | 1 | One-cycle strobe: the core took an exception or interrupt |
| aux_rdata | output | DATA_W | Read data, valid in the read cycle, 0 when no read is active |

## Verification
Clean pairs are read far from a lower-half wrap, and the status must come back as 1. Pairs are also placed so that the wrap falls at each significant edge: the lower read's own edge, an edge inside the window, and the upper read's own edge. This separates a correct carry window from one that is off by one cycle at either end. Exception strobes are placed inside the window, on the lower read, on the upper read and outside the pair, which shows exactly which cycles count. Orphan upper reads, restarted windows, unmapped addresses and enable toggling show the tracker and the counter are disturbed only by the accesses that should disturb them.

// File: rtl/snap_ctr_pkg.sv
package snap_ctr_pkg;

   // Readout tracker phases
   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,  // no pair started since reset
      TRK_OPEN = 2'd1,  // lower half read, upper half pending
      TRK_DONE = 2'd2   // a pair (or orphan upper read) completed
   } trk_state_e;

   // Number of bus-wide slices the counter is built from
   localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/snap_ctr_decode.sv
module snap_ctr_decode #(
   parameter int unsigned          ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]    CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0]    LOW_ADDR  = 'h104,
   parameter logic [ADDR_W-1:0]    HIGH_ADDR = 'h105
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   output logic              ctrl_rd_o,
   output logic              ctrl_wr_o,
   output logic              lo_rd_o,
   output logic              hi_rd_o,
   output logic              hit_o
);

   logic sel_ctrl, sel_lo, sel_hi;

   assign sel_ctrl  = (addr_i == CTRL_ADDR);
   assign sel_lo    = (addr_i == LOW_ADDR);
   assign sel_hi    = (addr_i == HIGH_ADDR);

   assign hit_o     = sel_ctrl | sel_lo | sel_hi;
   assign ctrl_rd_o = rd_i & sel_ctrl;
   assign ctrl_wr_o = wr_i & sel_ctrl;
   assign lo_rd_o   = rd_i & sel_lo;
   assign hi_rd_o   = rd_i & sel_hi;

endmodule

// File: rtl/snap_ctr_count.sv
module snap_ctr_count
   import snap_ctr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = NUM_HALVES * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr_i,
   input  logic             en_val_i,
   output logic             en_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             carry_o
);

   logic                  en_q;
   logic [NUM_HALVES:0]   step;   // step[h]: slice h advances this edge

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (en_wr_i) en_q <= en_val_i;
   end

   assign step[0] = en_q;

   // One slice per bus word; each slice advances when all below it wrap
   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_slice
      logic [DATA_W-1:0] slice_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       slice_q <= '0;
         else if (step[h]) slice_q <= slice_q + DATA_W'(1);
      end

      assign step[h+1]                   = step[h] & (&slice_q);
      assign cnt_o[h*DATA_W +: DATA_W]   = slice_q;
   end

   assign en_o    = en_q;
   assign carry_o = step[1];   // carry from the lower slice into the upper

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));                 // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(cnt_o));                                      // R3
   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i |=> (en_o == $past(en_val_i)));                         // R2

endmodule

// File: rtl/snap_ctr_tracker.sv
module snap_ctr_tracker
   import snap_ctr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lo_rd_i,
   input  logic hi_rd_i,
   input  logic carry_i,
   input  logic exc_i,
   output logic status_o
);

   trk_state_e st_q, st_d;
   logic       ok_q, ok_d;
   logic       tear;

   assign tear = carry_i | exc_i;

   always_comb begin
      st_d = st_q;
      ok_d = ok_q;
      if (lo_rd_i) begin
         // a lower read (re)opens the window; tearing in this cycle counts
         st_d = TRK_OPEN;
         ok_d = !tear;
      end else if (hi_rd_i) begin
         st_d = TRK_DONE;
         // upper half is sampled before this edge: events now do not tear
         ok_d = (st_q == TRK_OPEN) ? ok_q : 1'b0;
      end else if ((st_q == TRK_OPEN) && tear) begin
         ok_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TRK_IDLE;
         ok_q <= 1'b0;
      end else begin
         st_q <= st_d;
         ok_q <= ok_d;
      end
   end

   assign status_o = (st_q == TRK_DONE) & ok_q;

   AST_CARRY_TEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_i && !hi_rd_i && (lo_rd_i || st_q == TRK_OPEN)) |=> !ok_q);   // R5
   AST_EXC_TEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_i && !hi_rd_i && (lo_rd_i || st_q == TRK_OPEN)) |=> !ok_q);     // R6
   AST_ORPHAN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd_i && st_q != TRK_OPEN) |=> !status_o);                        // R7
   AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd_i |=> !status_o);                                               // R8
   AST_CLEAN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd_i && st_q == TRK_OPEN && ok_q) |=> status_o);                 // R4

endmodule

// File: rtl/snap_cycle_ctr.sv
module snap_cycle_ctr
   import snap_ctr_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0] LOW_ADDR  = 'h104,
   parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] aux_addr,
   input  logic              aux_rd_en,
   input  logic              aux_wr_en,
   input  logic [DATA_W-1:0] aux_wdata,
   input  logic              exc_taken,
   output logic [DATA_W-1:0] aux_rdata
);

   localparam int unsigned CNT_W   = NUM_HALVES * DATA_W;
   localparam int unsigned STAT_B  = DATA_W - 1;

   // Elaboration-time parameter checks (R11)
   if (DATA_W < 2) begin : g_bad_width
      $error("snap_cycle_ctr: DATA_W must be at least 2");
   end
   if ((CTRL_ADDR == LOW_ADDR) || (CTRL_ADDR == HIGH_ADDR) ||
       (LOW_ADDR == HIGH_ADDR)) begin : g_bad_map
      $error("snap_cycle_ctr: register addresses must be distinct");
   end

   logic             ctrl_rd, ctrl_wr, lo_rd, hi_rd, hit;
   logic             en, carry, status;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] ctrl_word;
   logic             unused_wdata;

   assign unused_wdata = ^aux_wdata[DATA_W-1:1];

   snap_ctr_decode #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .LOW_ADDR  (LOW_ADDR),
      .HIGH_ADDR (HIGH_ADDR)
   ) decode_i (
      .addr_i    (aux_addr),
      .rd_i      (aux_rd_en),
      .wr_i      (aux_wr_en),
      .ctrl_rd_o (ctrl_rd),
      .ctrl_wr_o (ctrl_wr),
      .lo_rd_o   (lo_rd),
      .hi_rd_o   (hi_rd),
      .hit_o     (hit)
   );

   snap_ctr_count #(
      .DATA_W (DATA_W)
   ) count_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr_i  (ctrl_wr),
      .en_val_i (aux_wdata[0]),
      .en_o     (en),
      .cnt_o    (cnt),
      .carry_o  (carry)
   );

   snap_ctr_tracker tracker_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_rd_i  (lo_rd),
      .hi_rd_i  (hi_rd),
      .carry_i  (carry),
      .exc_i    (exc_taken),
      .status_o (status)
   );

   always_comb begin
      ctrl_word         = '0;
      ctrl_word[STAT_B] = status;
      ctrl_word[0]      = en;
   end

   always_comb begin
      aux_rdata = '0;
      if (ctrl_rd)    aux_rdata = ctrl_word;
      else if (lo_rd) aux_rdata = cnt[DATA_W-1:0];
      else if (hi_rd) aux_rdata = cnt[CNT_W-1:DATA_W];
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_rd_en && !hit) |-> (aux_rdata == '0));                     // R10
   AST_CTRL_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |=> $stable(status));                                   // R9
   AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_wr_en && !ctrl_wr) |=> $stable(en));                       // R10

endmodule

// File: tb/snap_cycle_ctr_tb_top.sv
`timescale 1ns/1ps
module snap_cycle_ctr_tb_top;

   localparam int unsigned DW    = 8;
   localparam int unsigned AW    = 12;
   localparam logic [AW-1:0] A_CTRL = 12'h103;
   localparam logic [AW-1:0] A_LOW  = 12'h104;
   localparam logic [AW-1:0] A_HIGH = 12'h105;
   localparam logic [DW-1:0] ST_ON  = 8'h81;   // status bit DW-1 and enable
   localparam logic [DW-1:0] ST_OFF = 8'h01;   // enable only

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] aux_addr = '0;
   logic          aux_rd_en = 1'b0;
   logic          aux_wr_en = 1'b0;
   logic [DW-1:0] aux_wdata = '0;
   logic          exc_taken = 1'b0;
   logic [DW-1:0] aux_rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // Reference counter built from R2/R3
   logic [2*DW-1:0] mdl_cnt;
   logic            mdl_en;

   always #5 clk = ~clk;

   snap_cycle_ctr #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .aux_addr  (aux_addr),
      .aux_rd_en (aux_rd_en),
      .aux_wr_en (aux_wr_en),
      .aux_wdata (aux_wdata),
      .exc_taken (exc_taken),
      .aux_rdata (aux_rdata)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdl_cnt <= '0;
         mdl_en  <= 1'b0;
      end else begin
         if (mdl_en) mdl_cnt <= mdl_cnt + 1'b1;
         if (aux_wr_en && aux_addr == A_CTRL) mdl_en <= aux_wdata[0];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One bus cycle; starts just after a rising edge, ends just after the next
   task automatic bus(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic ex,
                      output logic [DW-1:0] rdat, output logic [2*DW-1:0] snap);
      @(negedge clk);
      aux_rd_en = rd; aux_wr_en = wr; aux_addr = a; aux_wdata = wd; exc_taken = ex;
      #1;
      rdat = aux_rdata;
      snap = mdl_cnt;
      @(posedge clk); #1;
      aux_rd_en = 1'b0; aux_wr_en = 1'b0; aux_addr = '0; aux_wdata = '0; exc_taken = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [2*DW-1:0] s);
      bus(1'b1, 1'b0, a, '0, 1'b0, d, s);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      bus(1'b0, 1'b1, a, v, 1'b0, d, s);
   endtask

   task automatic idle(input int n, input logic ex);
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      for (int i = 0; i < n; i++) bus(1'b0, 1'b0, '0, '0, ex, d, s);
   endtask

   task automatic wait_low(input logic [DW-1:0] v);
      while (mdl_cnt[DW-1:0] !== v) begin @(posedge clk); #1; end
   endtask

   task automatic t_reset();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      rd(A_CTRL, d, s); chk("R1 ctrl after reset", d, 0);
      rd(A_LOW, d, s);  chk("R1 low after reset", d, 0);
      rd(A_HIGH, d, s); chk("R1 high after reset", d, 0);
      rd(A_LOW, d, s);  chk("R3 held while disabled", d, 0);
   endtask

   task automatic t_enable();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      wr(A_CTRL, 8'hFF);
      rd(A_CTRL, d, s); chk("R2 enable readback, other bits 0", d, ST_OFF);
      idle(5, 1'b0);
      rd(A_LOW, d, s);  chk("R3 low half while counting", d, s[DW-1:0]);
      chk("R3 counter advanced", {31'b0, (s != 0)}, 1);
   endtask

   task automatic t_clean_pair();
      logic [DW-1:0] d, lo; logic [2*DW-1:0] s, sl;
      wait_low(8'h10);
      rd(A_LOW, lo, sl); chk("R3 low value", lo, sl[DW-1:0]);
      rd(A_HIGH, d, s);  chk("R3 high value", d, s[2*DW-1:DW]);
      rd(A_CTRL, d, s);  chk("R4 R11 clean pair status", d, ST_ON);
      rd(A_CTRL, d, s);  chk("R9 second ctrl read unchanged", d, ST_ON);
   endtask

   task automatic t_carry_between();
      logic [DW-1:0] d, lo; logic [2*DW-1:0] s, sl;
      wait_low(8'hFE);
      rd(A_LOW, lo, sl);
      idle(1, 1'b0);                       // carry at this cycle's edge
      rd(A_HIGH, d, s);
      chk("R5 high moved after low read", d, sl[2*DW-1:DW] + 1'b1);
      rd(A_CTRL, d, s);  chk("R5 carry inside window", d, ST_OFF);
   endtask

   task automatic t_carry_on_low();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      wait_low(8'hFF);
      rd(A_LOW, d, s); chk("R3 low at wrap", d, 8'hFF);
      rd(A_HIGH, d, s);
      rd(A_CTRL, d, s); chk("R5 carry on low read edge", d, ST_OFF);
   endtask

   task automatic t_carry_on_high();
      logic [DW-1:0] d, lo; logic [2*DW-1:0] s, sl;
      wait_low(8'hFE);
      rd(A_LOW, lo, sl);
      rd(A_HIGH, d, s);                    // low is FF here: carry at this edge
      chk("R5 high not yet moved", d, sl[2*DW-1:DW]);
      rd(A_CTRL, d, s); chk("R5 carry on high read edge is clean", d, ST_ON);
   endtask

   task automatic t_exceptions();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      wait_low(8'h20);
      rd(A_LOW, d, s); idle(1, 1'b1); rd(A_HIGH, d, s);
      rd(A_CTRL, d, s); chk("R6 exception inside window", d, ST_OFF);
      wait_low(8'h40);
      bus(1'b1, 1'b0, A_LOW, '0, 1'b1, d, s); rd(A_HIGH, d, s);
      rd(A_CTRL, d, s); chk("R6 exception on low read", d, ST_OFF);
      wait_low(8'h60);
      idle(1, 1'b1);
      rd(A_LOW, d, s);
      bus(1'b1, 1'b0, A_HIGH, '0, 1'b1, d, s);
      idle(1, 1'b1);
      rd(A_CTRL, d, s); chk("R6 exception outside window ignored", d, ST_ON);
   endtask

   task automatic t_orphan_and_window();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      rd(A_HIGH, d, s);
      rd(A_CTRL, d, s); chk("R7 upper read without lower", d, ST_OFF);
      wait_low(8'h80);
      rd(A_LOW, d, s);
      rd(A_CTRL, d, s); chk("R8 status 0 while window open", d, ST_OFF);
      rd(A_HIGH, d, s);
      rd(A_CTRL, d, s); chk("R8 pair closes after ctrl read", d, ST_ON);
      wait_low(8'hFE);
      rd(A_LOW, d, s); idle(1, 1'b0);      // torn window
      rd(A_LOW, d, s); rd(A_HIGH, d, s);   // restarted window
      rd(A_CTRL, d, s); chk("R8 second lower read restarts", d, ST_ON);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      rd(12'h106, d, s); chk("R10 unmapped read 0x106", d, 0);
      rd(12'h000, d, s); chk("R10 unmapped read 0x000", d, 0);
      wr(A_LOW, 8'h00); wr(A_HIGH, 8'h00); wr(12'h100, 8'h00);
      rd(A_CTRL, d, s); chk("R10 foreign writes keep enable", {31'b0, d[0]}, 1);
      rd(A_LOW, d, s);  chk("R10 foreign writes keep counter", d, s[DW-1:0]);
      rd(A_HIGH, d, s); chk("R10 foreign writes keep high", d, s[2*DW-1:DW]);
   endtask

   task automatic t_disable();
      logic [DW-1:0] d, l1; logic [2*DW-1:0] s;
      wr(A_CTRL, 8'h00);
      rd(A_CTRL, d, s); chk("R2 enable cleared", {31'b0, d[0]}, 0);
      rd(A_LOW, l1, s); idle(4, 1'b0);
      rd(A_LOW, d, s);  chk("R3 counter holds when disabled", d, l1);
   endtask

   task automatic t_midreset();
      logic [DW-1:0] d; logic [2*DW-1:0] s;
      wr(A_CTRL, 8'h01); idle(3, 1'b0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      rd(A_CTRL, d, s); chk("R1 ctrl after mid-run reset", d, 0);
      rd(A_HIGH, d, s); chk("R1 high after mid-run reset", d, 0);
      rd(A_LOW, d, s);  chk("R1 low after mid-run reset", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_enable();
      t_clean_pair();
      t_carry_between();
      t_carry_on_low();
      t_carry_on_high();
      t_exceptions();
      t_orphan_and_window();
      t_unmapped();
      t_disable();
      t_midreset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule